// File: doc/BRIEF.md
# Single-Port Power Sourcing Sequencer

This block is the control state machine for one powered-Ethernet source port. Once enabled, it checks for a valid resistive signature at the far end of the cable by stepping the bridge voltage low, high, then low again. It then classifies the load at a fixed class voltage and decides whether the measured class current suits the port's operating mode. If it does, the block ramps the converter to full output and watches the load current for overload. The analog bridge, the converter and the ADC sit outside the block. The sequencer only requests voltages and current limits, gates the pass switch and the switching clock, and reads back a bridge-null verdict and a current code in milliamps.

The operating mode comes from a three-bit strap that is latched once after reset. Two bits set which class currents are accepted and which overload threshold applies. The third bit chooses what happens after any failure: the port either waits a retry interval and starts over, or it stays in the fault state until the next reset. Every timed phase is measured in milliseconds by a cycle counter. Its terminal counts are parameters derived from the clock rate.

Top module: `poe_port_seq`

## Requirements
- R1: `strap_i` is sampled on the first clock edge after reset release and held until the next reset. Bits [1:0] select the class mode (0 full power, 1 class 1 only, 2 class 1 or 2, 3 full power). Bit [2] set to 1 selects automatic retry. Later changes to `strap_i` have no effect.
- R2: After reset, `state_o` is 0 (idle), `err_o` is 0, and `pass_en_o`, `sw_clk_en_o`, `vset_o` and `ilim_ma_o` are all 0. The port stays idle until `port_en_i` is high and the strap has been sampled.
- R3: Detection passes through states 1, 2 and 3, which request `vset_o` codes 1 (low signature voltage), 2 (high signature voltage) and 1 again. Each state lasts exactly STEP_MS*CYC_PER_MS cycles, and `pass_en_o` and `sw_clk_en_o` stay low throughout.
- R4: `null_ok_i` is sampled in the last cycle of each detection state. Any low sample sends the port to the fault state (7) on the next cycle. Only three high samples lead to classification (state 4).
- R5: In classification (state 4), `pass_en_o` and `sw_clk_en_o` are 1, `vset_o` is 3, and `ilim_ma_o` is CLS_ILIM_MA. The state lasts STEP_MS*CYC_PER_MS cycles, and `cur_ma_i` is judged in its last cycle.
- R6: The class current is accepted for any value in modes 0 and 3. In mode 1 it is accepted only from 8 to 13 mA inclusive, and in mode 2 only from 8 to 21 mA inclusive. An accepted current moves the port to state 5. A rejected current moves it to state 7.
- R7: In the ramp state (5), `vset_o` is 4 and `ilim_ma_o` is ILIM_MA (450). No overload is judged during this state. After STEP_MS*CYC_PER_MS cycles the port enters the powered state (6).
- R8: In state 6, if `cur_ma_i` is strictly greater than the mode's cut threshold, the port enters state 7 on the next cycle with power removed. The thresholds are 400 mA for modes 0 and 3, 98 mA for mode 1 and 180 mA for mode 2. A current equal to the threshold keeps the port powered.
- R9: In state 7, `err_o` is 1 and all drive outputs are 0. With retry selected, the port returns to idle after RETRY_MS*CYC_PER_MS cycles with `err_o` cleared. Without retry, it stays in state 7 until reset.
- R10: If `port_en_i` is low in state 6, the port returns to idle on the next cycle. In every state other than idle and powered, `port_en_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en_i | input | 1 | Request to run the port |
| strap_i | input | 3 | Mode strap: [1:0] class mode, [2] auto-retry |
| null_ok_i | input | 1 | Bridge null within tolerance |
| cur_ma_i | input | CUR_W | Measured port current in mA |
| pass_en_o | output | 1 | Pass switch enable |
| sw_clk_en_o | output | 1 | Switcher clock enable |
| vset_o | output | 3 | Voltage setpoint request code |
| ilim_ma_o | output | CUR_W | Current-limit request in mA |
| state_o | output | 3 | Sequencer state code |
| err_o | output | 1 | Fault indication |

## Verification
The bench tries all eight pass/fail patterns of the three signature points. A design that checked only the rising half would wrongly accept a failure on the final low step. It sweeps the class current through both edges of every mode's window. That exposes an off-by-one bound or a mode table that is swapped. It also drives the overload current to exactly the threshold and one above, which separates a strict compare from an inclusive one. The remaining tests cover a strap changed after capture, an overload applied during the ramp, and a dropped enable during classification. These catch a live strap, an early overload check and an enable that aborts too eagerly. Retry and latch-off are each timed to the cycle.

// File: rtl/poe_seq_pkg.sv
package poe_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_SIG_LO1 = 3'd1,
      ST_SIG_HI  = 3'd2,
      ST_SIG_LO2 = 3'd3,
      ST_CLASS   = 3'd4,
      ST_RAMP    = 3'd5,
      ST_ON      = 3'd6,
      ST_FAULT   = 3'd7
   } port_st_e;

   typedef enum logic [1:0] {
      MD_FULL     = 2'd0,
      MD_C1       = 2'd1,
      MD_C12      = 2'd2,
      MD_FULL_ALT = 2'd3
   } cls_mode_e;

   typedef enum logic [2:0] {
      VS_OFF    = 3'd0,
      VS_SIG_LO = 3'd1,
      VS_SIG_HI = 3'd2,
      VS_CLASS  = 3'd3,
      VS_RUN    = 3'd4
   } vset_e;

   typedef struct packed {
      logic      auto_retry;
      cls_mode_e cmode;
   } strap_cfg_t;

endpackage

// File: rtl/poe_strap_latch.sv
module poe_strap_latch
   import poe_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] strap_i,
   output strap_cfg_t cfg_o,
   output logic       valid_o
);

   strap_cfg_t cfg_q;
   logic       valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         valid_q <= 1'b0;
      end else if (!valid_q) begin
         cfg_q.auto_retry <= strap_i[2];
         cfg_q.cmode      <= cls_mode_e'(strap_i[1:0]);
         valid_q          <= 1'b1;
      end
   end

   assign cfg_o   = cfg_q;
   assign valid_o = valid_q;

   // R1: captured configuration never moves once taken
   assert_cfg_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && $past(valid_q)) |-> $stable(cfg_q));

endmodule

// File: rtl/poe_ms_timer.sv
module poe_ms_timer #(
   parameter int CYC_PER_MS = 100000,
   parameter int STEP_MS    = 20,
   parameter int RETRY_MS   = 1000,
   parameter bit PRESCALE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart_i,
   input  logic use_retry_i,
   output logic done_o
);

   localparam int STEP_CYC  = CYC_PER_MS * STEP_MS;
   localparam int RETRY_CYC = CYC_PER_MS * RETRY_MS;
   localparam int MAX_CYC   = (STEP_CYC > RETRY_CYC) ? STEP_CYC : RETRY_CYC;
   localparam int MAX_MS    = (STEP_MS > RETRY_MS) ? STEP_MS : RETRY_MS;

   if (CYC_PER_MS < 1 || STEP_MS < 1 || RETRY_MS < 1) begin : g_bad_cfg
      $error("poe_ms_timer: delays and clock ratio must be at least 1");
   end

   if (PRESCALE) begin : g_prescaled
      localparam int PRE_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
      localparam int MS_W  = $clog2(MAX_MS + 1);
      localparam logic [PRE_W-1:0] PRE_LAST  = PRE_W'(CYC_PER_MS - 1);
      localparam logic [MS_W-1:0]  STEP_LAST = MS_W'(STEP_MS - 1);
      localparam logic [MS_W-1:0]  RET_LAST  = MS_W'(RETRY_MS - 1);

      logic [PRE_W-1:0] pre_q;
      logic [MS_W-1:0]  ms_q;
      logic             pre_wrap;
      logic [MS_W-1:0]  ms_last;

      assign pre_wrap = (pre_q == PRE_LAST);
      assign ms_last  = use_retry_i ? RET_LAST : STEP_LAST;
      assign done_o   = pre_wrap && (ms_q == ms_last);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pre_q <= '0;
            ms_q  <= '0;
         end else if (restart_i) begin
            pre_q <= '0;
            ms_q  <= '0;
         end else if (!done_o) begin
            if (pre_wrap) begin
               pre_q <= '0;
               ms_q  <= ms_q + 1'b1;
            end else begin
               pre_q <= pre_q + 1'b1;
            end
         end
      end
   end else begin : g_flat
      localparam int CNT_W = $clog2(MAX_CYC + 1);
      localparam logic [CNT_W-1:0] STEP_LAST = CNT_W'(STEP_CYC - 1);
      localparam logic [CNT_W-1:0] RET_LAST  = CNT_W'(RETRY_CYC - 1);

      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] last;

      assign last   = use_retry_i ? RET_LAST : STEP_LAST;
      assign done_o = (cnt_q == last);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          cnt_q <= '0;
         else if (restart_i)  cnt_q <= '0;
         else if (!done_o)    cnt_q <= cnt_q + 1'b1;
      end
   end

   // R3: an expired interval stays expired until the owning state changes
   assert_done_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !restart_i) |=> done_o);

endmodule

// File: rtl/poe_class_judge.sv
module poe_class_judge
   import poe_seq_pkg::*;
#(
   parameter int CUR_W    = 10,
   parameter int C1_LO_MA = 8,
   parameter int C1_HI_MA = 13,
   parameter int C2_HI_MA = 21,
   parameter int CUT_FULL = 400,
   parameter int CUT_C1   = 98,
   parameter int CUT_C12  = 180
) (
   input  cls_mode_e        cmode_i,
   input  logic [CUR_W-1:0] cur_ma_i,
   output logic             win_ok_o,
   output logic             overload_o
);

   localparam logic [CUR_W-1:0] LO    = CUR_W'(C1_LO_MA);
   localparam logic [CUR_W-1:0] HI1   = CUR_W'(C1_HI_MA);
   localparam logic [CUR_W-1:0] HI2   = CUR_W'(C2_HI_MA);
   localparam logic [CUR_W-1:0] K_FUL = CUR_W'(CUT_FULL);
   localparam logic [CUR_W-1:0] K_C1  = CUR_W'(CUT_C1);
   localparam logic [CUR_W-1:0] K_C12 = CUR_W'(CUT_C12);

   if ((2 ** CUR_W) <= CUT_FULL || (2 ** CUR_W) <= CUT_C12) begin : g_bad_width
      $error("poe_class_judge: CUR_W too narrow for cut thresholds");
   end
   if (C1_LO_MA > C1_HI_MA || C1_HI_MA > C2_HI_MA) begin : g_bad_window
      $error("poe_class_judge: class windows out of order");
   end

   logic [CUR_W-1:0] cut;

   always_comb begin
      unique case (cmode_i)
         MD_C1:   win_ok_o = (cur_ma_i >= LO) && (cur_ma_i <= HI1);
         MD_C12:  win_ok_o = (cur_ma_i >= LO) && (cur_ma_i <= HI2);
         default: win_ok_o = 1'b1;
      endcase
   end

   always_comb begin
      unique case (cmode_i)
         MD_C1:   cut = K_C1;
         MD_C12:  cut = K_C12;
         default: cut = K_FUL;
      endcase
   end

   assign overload_o = (cur_ma_i > cut);

   // R6: a current below the common lower bound is rejected in restricted modes
   assert_low_reject_R6: assert final (
      !((cmode_i == MD_C1 || cmode_i == MD_C12) && cur_ma_i < LO) || !win_ok_o);

endmodule

// File: rtl/poe_port_seq.sv
module poe_port_seq
   import poe_seq_pkg::*;
#(
   parameter int CUR_W       = 10,
   parameter int CYC_PER_MS  = 100000,
   parameter int STEP_MS     = 20,
   parameter int RETRY_MS    = 1000,
   parameter bit PRESCALE    = 1'b1,
   parameter int CLS_ILIM_MA = 100,
   parameter int ILIM_MA     = 450
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             port_en_i,
   input  logic [2:0]       strap_i,
   input  logic             null_ok_i,
   input  logic [CUR_W-1:0] cur_ma_i,
   output logic             pass_en_o,
   output logic             sw_clk_en_o,
   output logic [2:0]       vset_o,
   output logic [CUR_W-1:0] ilim_ma_o,
   output logic [2:0]       state_o,
   output logic             err_o
);

   localparam logic [CUR_W-1:0] CLS_LIM = CUR_W'(CLS_ILIM_MA);
   localparam logic [CUR_W-1:0] RUN_LIM = CUR_W'(ILIM_MA);

   if ((2 ** CUR_W) <= ILIM_MA || CLS_ILIM_MA > ILIM_MA) begin : g_bad_lim
      $error("poe_port_seq: current limit settings do not fit CUR_W");
   end

   strap_cfg_t cfg;
   logic       cfg_vld;
   logic       tmr_done;
   logic       restart;
   logic       win_ok;
   logic       overload;
   port_st_e   st_q, st_nxt;

   poe_strap_latch u_strap (
      .clk     (clk),
      .rst_n   (rst_n),
      .strap_i (strap_i),
      .cfg_o   (cfg),
      .valid_o (cfg_vld)
   );

   poe_ms_timer #(
      .CYC_PER_MS (CYC_PER_MS),
      .STEP_MS    (STEP_MS),
      .RETRY_MS   (RETRY_MS),
      .PRESCALE   (PRESCALE)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .restart_i   (restart),
      .use_retry_i (st_q == ST_FAULT),
      .done_o      (tmr_done)
   );

   poe_class_judge #(
      .CUR_W (CUR_W)
   ) u_judge (
      .cmode_i    (cfg.cmode),
      .cur_ma_i   (cur_ma_i),
      .win_ok_o   (win_ok),
      .overload_o (overload)
   );

   always_comb begin
      st_nxt = st_q;
      unique case (st_q)
         ST_IDLE:    if (cfg_vld && port_en_i) st_nxt = ST_SIG_LO1;
         ST_SIG_LO1: if (tmr_done) st_nxt = null_ok_i ? ST_SIG_HI  : ST_FAULT;
         ST_SIG_HI:  if (tmr_done) st_nxt = null_ok_i ? ST_SIG_LO2 : ST_FAULT;
         ST_SIG_LO2: if (tmr_done) st_nxt = null_ok_i ? ST_CLASS   : ST_FAULT;
         ST_CLASS:   if (tmr_done) st_nxt = win_ok ? ST_RAMP : ST_FAULT;
         ST_RAMP:    if (tmr_done) st_nxt = ST_ON;
         ST_ON: begin
            if (overload)        st_nxt = ST_FAULT;
            else if (!port_en_i) st_nxt = ST_IDLE;
         end
         ST_FAULT:   if (cfg.auto_retry && tmr_done) st_nxt = ST_IDLE;
         default:    st_nxt = ST_IDLE;
      endcase
   end

   assign restart = (st_nxt != st_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_nxt;
   end

   logic powered;
   assign powered = (st_q == ST_CLASS) || (st_q == ST_RAMP) || (st_q == ST_ON);

   always_comb begin
      unique case (st_q)
         ST_SIG_LO1, ST_SIG_LO2: vset_o = VS_SIG_LO;
         ST_SIG_HI:              vset_o = VS_SIG_HI;
         ST_CLASS:               vset_o = VS_CLASS;
         ST_RAMP, ST_ON:         vset_o = VS_RUN;
         default:                vset_o = VS_OFF;
      endcase
   end

   always_comb begin
      unique case (st_q)
         ST_CLASS:       ilim_ma_o = CLS_LIM;
         ST_RAMP, ST_ON: ilim_ma_o = RUN_LIM;
         default:        ilim_ma_o = '0;
      endcase
   end

   assign pass_en_o   = powered;
   assign sw_clk_en_o = powered;
   assign state_o     = st_q;
   assign err_o       = (st_q == ST_FAULT);

   // R3: the high step is entered only from the first low step
   assert_hi_after_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SIG_HI && $past(st_q) != ST_SIG_HI) |-> $past(st_q) == ST_SIG_LO1);

   // R4: classification is entered only after the falling low step
   assert_class_after_sig_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_CLASS && $past(st_q) != ST_CLASS) |-> $past(st_q) == ST_SIG_LO2);

   // R6: a rejected class current at the sample point leads to fault
   assert_cls_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_CLASS && tmr_done && !win_ok) |=> (st_q == ST_FAULT));

   // R8: overload while powered removes power on the next cycle
   assert_overload_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ON && overload) |=> (st_q == ST_FAULT && !pass_en_o));

   // R9: without retry a fault is held
   assert_latch_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FAULT && !cfg.auto_retry) |=> (st_q == ST_FAULT));

endmodule

// File: tb/tb_poe_port_seq.sv
module tb_poe_port_seq;

   localparam int CUR_W = 10;
   localparam int CYC   = 2;
   localparam int STEP  = 20;
   localparam int RET   = 5;
   localparam int N     = CYC * STEP;
   localparam int NR    = CYC * RET;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             port_en_i = 1'b0;
   logic [2:0]       strap_i = 3'd0;
   logic             null_ok_i = 1'b0;
   logic [CUR_W-1:0] cur_ma_i = '0;
   logic             pass_en_o, sw_clk_en_o, err_o;
   logic [2:0]       vset_o, state_o;
   logic [CUR_W-1:0] ilim_ma_o;

   int errs = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   poe_port_seq #(
      .CUR_W (CUR_W), .CYC_PER_MS (CYC), .STEP_MS (STEP), .RETRY_MS (RET)
   ) dut (
      .clk (clk), .rst_n (rst_n), .port_en_i (port_en_i), .strap_i (strap_i),
      .null_ok_i (null_ok_i), .cur_ma_i (cur_ma_i), .pass_en_o (pass_en_o),
      .sw_clk_en_o (sw_clk_en_o), .vset_o (vset_o), .ilim_ma_o (ilim_ma_o),
      .state_o (state_o), .err_o (err_o)
   );

   task automatic chk(input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic adv(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   function automatic int cut_of(input int m);
      if (m == 1) return 98;
      if (m == 2) return 180;
      return 400;
   endfunction

   function automatic bit win_of(input int m, input int c);
      if (m == 1) return (c >= 8 && c <= 13);
      if (m == 2) return (c >= 8 && c <= 21);
      return 1'b1;
   endfunction

   task automatic reset_dut(input logic [2:0] s);
      @(negedge clk);
      rst_n = 1'b0; port_en_i = 1'b0; null_ok_i = 1'b0; cur_ma_i = '0; strap_i = s;
      adv(3);
      rst_n = 1'b1;
      adv(1);
   endtask

   // runs the three signature steps; returns 1 if classification was reached
   task automatic detect(input bit [2:0] v, output bit reached);
      int exp_vs [3] = '{1, 2, 1};
      reached = 1'b0;
      port_en_i = 1'b1;
      adv(1);
      for (int k = 0; k < 3; k++) begin
         chk(state_o, k + 1, "R3 signature step state");
         chk(vset_o, exp_vs[k], "R3 signature voltage code");
         chk({pass_en_o, sw_clk_en_o}, 0, "R3 switches off in detection");
         null_ok_i = v[k];
         adv(N - 1);
         chk(state_o, k + 1, "R3 step still held at last cycle");
         adv(1);
         if (!v[k]) begin
            chk(state_o, 7, "R4 failed null point gives fault");
            return;
         end
      end
      chk(state_o, 4, "R4 three good points reach class");
      reached = 1'b1;
   endtask

   task automatic classify(input int m, input int c);
      chk({pass_en_o, sw_clk_en_o}, 3, "R5 class switches on");
      chk(vset_o, 3, "R5 class voltage code");
      chk(ilim_ma_o, 100, "R5 class current limit");
      cur_ma_i = CUR_W'(c);
      adv(N);
      chk(state_o, win_of(m, c) ? 5 : 7, $sformatf("R6 mode %0d class %0d mA", m, c));
   endtask

   task automatic ramp_up();
      chk(vset_o, 4, "R7 ramp voltage code");
      chk(ilim_ma_o, 450, "R7 ramp current limit");
      cur_ma_i = CUR_W'(500);
      adv(N);
      chk(state_o, 6, "R7 ramp ignores overload and reaches powered");
      cur_ma_i = '0;
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         errs++; checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      bit ok;

      // R2: reset state and idle without enable
      reset_dut(3'b000);
      chk(state_o, 0, "R2 reset state");
      chk({pass_en_o, sw_clk_en_o, err_o}, 0, "R2 reset outputs");
      chk(vset_o, 0, "R2 reset voltage code");
      chk(ilim_ma_o, 0, "R2 reset current limit");
      adv(10);
      chk(state_o, 0, "R2 idle held without enable");

      // R3/R4: every signature pattern
      for (int p = 0; p < 8; p++) begin
         reset_dut(3'b000);
         detect(p[2:0], ok);
         chk(ok, (p == 7) ? 1 : 0, "R4 only all-good signature passes");
         if (!ok) chk(err_o, 1, "R9 error flag on signature fault");
      end

      // R5/R6: class window sweep per mode
      for (int m = 0; m < 4; m++) begin
         for (int c = 0; c <= 25; c++) begin
            reset_dut(m[2:0]);
            detect(3'b111, ok);
            classify(m, c);
         end
         reset_dut(m[2:0]);
         detect(3'b111, ok);
         classify(m, 399);
      end

      // R8/R9: overload threshold edge and latch-off per mode
      for (int m = 0; m < 4; m++) begin
         reset_dut(m[2:0]);
         detect(3'b111, ok);
         classify(m, 10);
         ramp_up();
         cur_ma_i = CUR_W'(cut_of(m));
         adv(1);
         chk(state_o, 6, "R8 current at threshold stays powered");
         cur_ma_i = CUR_W'(cut_of(m) + 1);
         adv(1);
         chk(state_o, 7, "R8 current above threshold faults");
         chk({pass_en_o, sw_clk_en_o}, 0, "R8 power removed on overload");
         chk(err_o, 1, "R9 error flag on overload");
         adv(3 * NR);
         chk(state_o, 7, "R9 latch-off holds fault");
      end

      // R9: retry timing
      reset_dut(3'b100);
      detect(3'b000, ok);
      port_en_i = 1'b0;
      adv(NR - 1);
      chk(state_o, 7, "R9 fault held for retry interval");
      adv(1);
      chk(state_o, 0, "R9 retry returns to idle");
      chk(err_o, 0, "R9 error cleared on retry");
      chk(vset_o, 0, "R9 outputs off after retry");

      // R1: strap changes after capture are ignored
      reset_dut(3'b001);
      strap_i = 3'b000;
      detect(3'b111, ok);
      classify(1, 20);
      reset_dut(3'b000);
      strap_i = 3'b100;
      detect(3'b011, ok);
      adv(3 * NR);
      chk(state_o, 7, "R1 late retry strap ignored");

      // R10: enable drop while powered, ignored during class
      reset_dut(3'b000);
      detect(3'b111, ok);
      port_en_i = 1'b0;
      classify(0, 10);
      chk(state_o, 5, "R10 enable ignored in class");
      port_en_i = 1'b1;
      ramp_up();
      port_en_i = 1'b0;
      adv(1);
      chk(state_o, 0, "R10 enable low returns to idle");
      chk(pass_en_o, 0, "R10 power removed on disable");

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule